// File: doc/BRIEF.md
# Inter-Processor Mailbox Hub

The mailbox hub lets several processors exchange 32-bit words through a set of independent one-way queues. It sits on a plain 32-bit register bus. Writing a queue's message register appends a word to that queue, and reading the same register removes the oldest word. Each queue also exposes a full flag and a word count, so a sender can test for room and a receiver can test for data.

Every queue produces two events: a new word was accepted, or a pop took the queue from full to not full. Each event sets a bit in the status register of every user. Each user has its own enable register that picks which events reach that user's interrupt line. Status bits are cleared by writing ones. The interrupt line of a user is registered, and it is high while any enabled status bit is set.

With the default parameters there are four queues of four words each and four users. Bus reads return their data on the cycle after the request.

Top module: `mbox_hub`

## Requirements
- R1: Offset 0x000 reads 0x00000021: major version 2 in bits 7:4 and minor version 1 in bits 3:0. Writes to it are ignored.
- R2: A write to offset 0x040+4*m appends the write data to queue m. A read of that offset removes the oldest word and returns it on `bus_rdata` in the cycle after the request. Words leave in the order they entered.
- R3: Each queue holds at most 4 words, and a write to a full queue is dropped. Offset 0x080+4*m reads 1 while queue m is full and 0 otherwise.
- R4: A read of an empty queue's message register returns 0 and changes no state.
- R5: Offset 0x0C0+4*m reads the number of words held in queue m. Writes to the count and full registers are ignored.
- R6: An accepted write to queue m sets status bit 2*m in the status register of every user, at offset 0x100+8*u. A read that takes queue m from full to not full sets bit 2*m+1 in every user's status register.
- R7: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. A later read returns the updated value, and each user's status register is separate from the others.
- R8: The enable register of user u, at offset 0x104+8*u, holds bits 7:0 as written and reads them back.
- R9: `irq_o[u]` rises one cycle after status and enable of user u share a set bit. It falls one cycle after they no longer share one.
- R10: Queues are independent of each other. Unmapped or misaligned offsets read 0.
- R11: After reset, all queues are empty and every status and enable register is 0. `bus_rdata` and `irq_o` are 0, and the revision still reads 0x21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 4 | One interrupt line per user |

## Verification
A broken queue pointer or count shows up at the ports on the next read. That read returns a word out of order, a wrong count, or a nonzero value where the queue should be empty. A status bit that sets on the wrong event, or clears on a zero write, appears as a wrong status readback. The same fault also shows on `irq_o` exactly one cycle after the status changes. The bench therefore checks the interrupt lines both in the lag cycle and in the cycle after it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int MBX_QUEUES = 4;
    localparam int MBX_USERS  = 4;
    localparam int MBX_DEPTH  = 4;
    localparam int MBX_DW     = 32;
    localparam int MBX_AW     = 9;
    localparam int MBX_IDX_W  = 4;

    localparam logic [3:0] MBX_REV_MAJOR = 4'd2;
    localparam logic [3:0] MBX_REV_MINOR = 4'd1;

    localparam logic [MBX_AW-1:0] MBX_MSG_BASE  = 9'h040;
    localparam logic [MBX_AW-1:0] MBX_FULL_BASE = 9'h080;
    localparam logic [MBX_AW-1:0] MBX_CNT_BASE  = 9'h0C0;
    localparam logic [MBX_AW-1:0] MBX_USR_BASE  = 9'h100;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_REV,
        RG_MSG,
        RG_FULL,
        RG_CNT,
        RG_STAT,
        RG_EN
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e              kind;
        logic [MBX_IDX_W-1:0]   idx;
    } reg_sel_t;

    // Map a byte offset onto a register kind and an index.
    function automatic reg_sel_t mbx_decode(input logic [MBX_AW-1:0] a,
                                            input int nq, input int nu);
        reg_sel_t r;
        r.kind = RG_NONE;
        r.idx  = a[5:2];
        if (a[1:0] == 2'b00) begin
            case (a[8:6])
                3'd0: if (a[5:2] == 4'd0) r.kind = RG_REV;
                3'd1: if (int'(a[5:2]) < nq) r.kind = RG_MSG;
                3'd2: if (int'(a[5:2]) < nq) r.kind = RG_FULL;
                3'd3: if (int'(a[5:2]) < nq) r.kind = RG_CNT;
                3'd4: begin
                    r.idx = {2'b00, a[4:3]};
                    if (!a[5] && int'(a[4:3]) < nu)
                        r.kind = a[2] ? RG_EN : RG_STAT;
                end
                default: r.kind = RG_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          push_ok,
    output logic          pop_was_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full         = (cnt == CW'(DEPTH));
    assign push_ok      = push && !full;
    assign pop_ok       = pop && (cnt != '0);
    assign pop_was_full = pop_ok && full;
    assign head         = (cnt != '0) ? mem[rd_ptr] : '0;
    assign count        = cnt;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
            else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/mbox_user_regs.sv
module mbox_user_regs #(
    parameter int EVW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [EVW-1:0] ev,
    input  logic           wr_stat,
    input  logic           wr_en,
    input  logic [EVW-1:0] wdata,
    output logic [EVW-1:0] stat,
    output logic [EVW-1:0] en,
    output logic           irq
);
    logic [EVW-1:0] clr;

    assign clr = wr_stat ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en   <= '0;
            irq  <= 1'b0;
        end else begin
            stat <= (stat & ~clr) | ev;
            if (wr_en) en <= wdata;
            irq  <= |(stat & en);
        end
    end
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub
    import mbox_pkg::*;
#(
    parameter int NUM_Q = MBX_QUEUES,
    parameter int NUM_U = MBX_USERS,
    parameter int DEPTH = MBX_DEPTH,
    parameter int DW    = MBX_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [MBX_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_U-1:0]  irq_o
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int EVW = 2 * NUM_Q;
    localparam int QIW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int UIW = (NUM_U > 1) ? $clog2(NUM_U) : 1;

    reg_sel_t                     sel;
    logic                         acc_wr, acc_rd;
    logic [NUM_Q-1:0][DW-1:0]     q_head;
    logic [NUM_Q-1:0][CW-1:0]     q_count;
    logic [NUM_Q-1:0]             q_full, q_push_ok, q_pop_full;
    logic [EVW-1:0]               ev;
    logic [NUM_U-1:0][EVW-1:0]    stat_q, en_q;
    logic [QIW-1:0]               qi;
    logic [UIW-1:0]               ui;
    logic [DW-1:0]                rd_val;

    assign sel    = mbx_decode(bus_addr, NUM_Q, NUM_U);
    assign acc_wr = bus_sel && bus_wr;
    assign acc_rd = bus_sel && !bus_wr;
    assign qi     = sel.idx[QIW-1:0];
    assign ui     = sel.idx[UIW-1:0];

    for (genvar m = 0; m < NUM_Q; m++) begin : g_q
        logic hit;
        assign hit = (sel.kind == RG_MSG) && (sel.idx == MBX_IDX_W'(m));
        mbox_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_fifo (
            .clk          (clk),
            .rst          (rst),
            .push         (acc_wr && hit),
            .pop          (acc_rd && hit),
            .wdata        (bus_wdata),
            .head         (q_head[m]),
            .count        (q_count[m]),
            .full         (q_full[m]),
            .push_ok      (q_push_ok[m]),
            .pop_was_full (q_pop_full[m])
        );
        assign ev[2*m]   = q_push_ok[m];
        assign ev[2*m+1] = q_pop_full[m];
    end

    for (genvar u = 0; u < NUM_U; u++) begin : g_u
        logic me;
        assign me = (sel.idx == MBX_IDX_W'(u));
        mbox_user_regs #(.EVW(EVW)) u_regs (
            .clk     (clk),
            .rst     (rst),
            .ev      (ev),
            .wr_stat (acc_wr && me && sel.kind == RG_STAT),
            .wr_en   (acc_wr && me && sel.kind == RG_EN),
            .wdata   (bus_wdata[EVW-1:0]),
            .stat    (stat_q[u]),
            .en      (en_q[u]),
            .irq     (irq_o[u])
        );
    end

    always_comb begin
        rd_val = '0;
        case (sel.kind)
            RG_REV:  rd_val = DW'({MBX_REV_MAJOR, MBX_REV_MINOR});
            RG_MSG:  rd_val = q_head[qi];
            RG_FULL: rd_val = DW'(q_full[qi]);
            RG_CNT:  rd_val = DW'(q_count[qi]);
            RG_STAT: rd_val = DW'(stat_q[ui]);
            RG_EN:   rd_val = DW'(en_q[ui]);
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (acc_rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/mbox_hub_chk.sv
module mbox_hub_chk
    import mbox_pkg::*;
#(
    parameter int NUM_Q = 4,
    parameter int NUM_U = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int CW    = 3,
    parameter int EVW   = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [MBX_AW-1:0]         bus_addr,
    input logic [DW-1:0]             bus_rdata,
    input logic [NUM_Q-1:0][CW-1:0]  q_count,
    input logic [NUM_Q-1:0]          q_full,
    input logic [NUM_U-1:0][EVW-1:0] stat_q,
    input logic [NUM_U-1:0][EVW-1:0] en_q,
    input logic [NUM_U-1:0]          irq_o
);
    for (genvar m = 0; m < NUM_Q; m++) begin : g_qa
        logic msg_hit;
        assign msg_hit = bus_sel && (bus_addr == MBX_AW'(MBX_MSG_BASE + 4*m));

        assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
            q_count[m] <= CW'(DEPTH));

        assert_drop_full_R3: assert property (@(posedge clk) disable iff (rst)
            (msg_hit && bus_wr && q_full[m]) |=> $stable(q_count[m]));

        assert_empty_zero_R4: assert property (@(posedge clk) disable iff (rst)
            (msg_hit && !bus_wr && q_count[m] == '0) |=> (bus_rdata == '0));

        for (genvar u = 0; u < NUM_U; u++) begin : g_ua
            assert_newmsg_R6: assert property (@(posedge clk) disable iff (rst)
                (msg_hit && bus_wr && !q_full[m]) |=> stat_q[u][2*m]);
        end
    end

    for (genvar u = 0; u < NUM_U; u++) begin : g_irq
        assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
            irq_o[u] |-> $past(|(stat_q[u] & en_q[u])));
    end
endmodule

bind mbox_hub mbox_hub_chk #(
    .NUM_Q(NUM_Q), .NUM_U(NUM_U), .DEPTH(DEPTH), .DW(DW), .CW(CW), .EVW(EVW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .q_count   (q_count),
    .q_full    (q_full),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .irq_o     (irq_o)
);

// File: tb/sim_mbox_hub.sv
`timescale 1ns/1ps
module sim_mbox_hub;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mbox_hub u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [8:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 9'h000, 32'h0,        32'h21,       8'd1},  // R1 revision
        '{1'b0, 9'h0C0, 32'h0,        32'h0,        8'd5},  // R5 empty count
        '{1'b1, 9'h040, 32'hA0,       32'h0,        8'd2},
        '{1'b1, 9'h040, 32'hA1,       32'h0,        8'd2},
        '{1'b0, 9'h0C0, 32'h0,        32'h2,        8'd5},  // R5 count 2
        '{1'b0, 9'h100, 32'h0,        32'h1,        8'd6},  // R6 user0 new msg
        '{1'b0, 9'h108, 32'h0,        32'h1,        8'd6},  // R6 user1 new msg
        '{1'b0, 9'h080, 32'h0,        32'h0,        8'd3},  // R3 not full
        '{1'b1, 9'h040, 32'hA2,       32'h0,        8'd2},
        '{1'b1, 9'h040, 32'hA3,       32'h0,        8'd2},
        '{1'b0, 9'h080, 32'h0,        32'h1,        8'd3},  // R3 full
        '{1'b1, 9'h040, 32'hA4,       32'h0,        8'd3},  // R3 dropped
        '{1'b0, 9'h0C0, 32'h0,        32'h4,        8'd3},  // R3 count holds at 4
        '{1'b0, 9'h040, 32'h0,        32'hA0,       8'd2},  // R2 oldest first
        '{1'b0, 9'h100, 32'h0,        32'h3,        8'd6},  // R6 not-full event
        '{1'b1, 9'h100, 32'h1,        32'h0,        8'd7},
        '{1'b0, 9'h100, 32'h0,        32'h2,        8'd7},  // R7 bit0 cleared
        '{1'b1, 9'h100, 32'h0,        32'h0,        8'd7},
        '{1'b0, 9'h100, 32'h0,        32'h2,        8'd7},  // R7 zero write no effect
        '{1'b0, 9'h040, 32'h0,        32'hA1,       8'd2},  // R2
        '{1'b0, 9'h040, 32'h0,        32'hA2,       8'd2},  // R2
        '{1'b0, 9'h040, 32'h0,        32'hA3,       8'd2},  // R2
        '{1'b0, 9'h040, 32'h0,        32'h0,        8'd4},  // R4 empty read 0
        '{1'b0, 9'h0C0, 32'h0,        32'h0,        8'd4},  // R4 count stays 0
        '{1'b0, 9'h100, 32'h0,        32'h2,        8'd4},  // R4 no event
        '{1'b1, 9'h104, 32'h5,        32'h0,        8'd8},
        '{1'b0, 9'h104, 32'h0,        32'h5,        8'd8},  // R8 enable readback
        '{1'b1, 9'h04C, 32'hB0,       32'h0,        8'd10},
        '{1'b0, 9'h118, 32'h0,        32'h43,       8'd6},  // R6 user3 bits 0,1,6
        '{1'b0, 9'h100, 32'h0,        32'h42,       8'd10}, // R10 queue 3 event
        '{1'b0, 9'h0CC, 32'h0,        32'h1,        8'd10}, // R10
        '{1'b0, 9'h0C4, 32'h0,        32'h0,        8'd10}, // R10 queue 1 untouched
        '{1'b1, 9'h108, 32'hFFFFFFFF, 32'h0,        8'd7},
        '{1'b0, 9'h108, 32'h0,        32'h0,        8'd7},  // R7 all cleared
        '{1'b0, 9'h100, 32'h0,        32'h42,       8'd7},  // R7 other user kept
        '{1'b0, 9'h060, 32'h0,        32'h0,        8'd10}, // R10 unmapped
        '{1'b0, 9'h11C, 32'h0,        32'h0,        8'd8},  // R8 user3 enable
        '{1'b1, 9'h0CC, 32'h7,        32'h0,        8'd5},
        '{1'b0, 9'h0CC, 32'h0,        32'h1,        8'd5},  // R5 write ignored
        '{1'b1, 9'h000, 32'hFF,       32'h0,        8'd1},
        '{1'b0, 9'h000, 32'h0,        32'h21,       8'd1},  // R1 write ignored
        '{1'b0, 9'h04C, 32'h0,        32'hB0,       8'd2},  // R2 queue 3 pop
        '{1'b0, 9'h118, 32'h0,        32'h43,       8'd6},  // R6 no not-full event
        '{1'b0, 9'h042, 32'h0,        32'h0,        8'd10}  // R10 misaligned
    };

    task automatic check(input int req, input logic [31:0] got,
                         input logic [31:0] exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(11, bus_rdata, 32'h0, "rdata after reset");   // R11
        check(11, {28'h0, irq_o}, 32'h0, "irq after reset"); // R11

        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i].wr, VEC[i].addr, VEC[i].data);
            if (!VEC[i].wr)
                check(int'(VEC[i].req), bus_rdata, VEC[i].exp, $sformatf("vector %0d", i));
        end

        // R9: no enabled status set anywhere
        check(9, {28'h0, irq_o}, 32'h0, "irq idle");
        // R9: user2 enables new-msg q0 while its status already holds it
        bus_op(1'b1, 9'h114, 32'h1);
        tick();
        check(9, {28'h0, irq_o}, 32'h4, "irq user2 on");
        // R9: clear user2 status, line falls one cycle later
        bus_op(1'b1, 9'h110, 32'hFF);
        tick();
        check(9, {28'h0, irq_o}, 32'h0, "irq user2 off");
        // R9: a push raises users 0 and 2 with one cycle of lag
        bus_op(1'b1, 9'h040, 32'hC0);
        check(9, {28'h0, irq_o}, 32'h0, "irq lag cycle");
        tick();
        check(9, {28'h0, irq_o}, 32'h5, "irq users 0 and 2");
        // R8/R9: disable user2
        bus_op(1'b1, 9'h114, 32'h0);
        tick();
        check(9, {28'h0, irq_o}, 32'h1, "irq user2 disabled");

        // R11: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check(11, {28'h0, irq_o}, 32'h0, "irq after second reset");
        bus_op(1'b0, 9'h0C0, 32'h0);
        check(11, bus_rdata, 32'h0, "count after reset");
        bus_op(1'b0, 9'h100, 32'h0);
        check(11, bus_rdata, 32'h0, "status after reset");
        bus_op(1'b0, 9'h104, 32'h0);
        check(11, bus_rdata, 32'h0, "enable after reset");
        bus_op(1'b0, 9'h000, 32'h0);
        check(11, bus_rdata, 32'h21, "revision after reset");

        finish_run();
    end
endmodule